// File: doc/BRIEF.md
# Dual-Clock FIFO with Selectable Read-Ahead

This block moves data words from a producer running on one clock to a consumer running on an unrelated clock. Words go into an inferred dual-port array through a valid/ready write port. They leave through an output register on the read clock. Each pointer is Gray-coded before it crosses to the other clock. Every status flag is formed from pointers that have passed through a two-flop synchronizer clocked by the port that observes the flag.

A static mode pin selects one of two read behaviours. In standard mode, `rd_valid` acts as an empty flag: HIGH means at least one word waits in memory. A request on `rd_ready` while `rd_valid` is HIGH copies the head word into `rd_data` on the next read edge. In read-ahead mode, the head word is moved into the output register without any request, and `rd_valid` acts as output-ready. A request while `rd_valid` is HIGH consumes the presented word. Back-pressure on the write side is `wr_ready`: a word is taken only on an edge where `wr_valid` and `wr_ready` are both HIGH. On the read side, a request while `rd_valid` is LOW is ignored in both modes.

Occupancy is counted in memory only, so the word held in the output register is never counted. Two programmable offsets set the almost-empty and almost-full thresholds. A configuration write through the write port loads both offsets. `rst_n` is asynchronous and is shared by both clock domains. It must be held LOW across several edges of both clocks, and `fwft_mode` may change only while reset is LOW.

Top module: `dual_clock_fifo`

## Requirements
- R1: While reset is LOW and just after it is released, `rd_valid`=0, `almost_empty_n`=0, `wr_ready`=1 and `almost_full_n`=1, and the offsets take their default values (almost-empty X=2, almost-full Y=2, depth D=16).
- R2: A word is stored only on a write-clock edge with `wr_valid`=1, `wr_cfg`=0 and `wr_ready`=1. `wr_ready` is LOW exactly when the write-side memory count equals D, and a write attempted while it is LOW leaves the stored contents unchanged.
- R3: In standard mode (`fwft_mode`=0), `rd_valid` rises on the second read-clock edge after a write into an empty memory. A request while `rd_valid`=1 loads the head word into `rd_data` on the next read edge, and a request while `rd_valid`=0 is ignored with `rd_data` held.
- R4: In read-ahead mode (`fwft_mode`=1), a word written into an empty block appears on `rd_data` with `rd_valid` rising on the third read-clock edge after the write, with no request.
- R5: In read-ahead mode, `rd_ready`=1 with `rd_valid`=1 consumes the presented word. The next stored word is presented on the same edge, or `rd_valid` falls if memory is empty. A request while `rd_valid`=0 is ignored.
- R6: The word in the output register is not part of the memory count. In read-ahead mode, the block therefore accepts D+1 words before `wr_ready` goes LOW.
- R7: `almost_empty_n` is HIGH exactly when the read-side memory count N satisfies N > X.
- R8: `almost_full_n` is LOW exactly when the write-side memory count N satisfies N >= D-Y, and it is LOW whenever `wr_ready` is LOW.
- R9: A write-port transfer with `wr_valid`=1 and `wr_cfg`=1 loads X from `wr_data[3:0]` and Y from `wr_data[7:4]`. It stores no data word.
- R10: Words leave in the order they were accepted, with their values unchanged, in both modes and under stalls on either side.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| wr_clk | input | 1 | Write-side clock |
| rst_n | input | 1 | Asynchronous active-low reset for both domains |
| wr_valid | input | 1 | Producer offers a word or a configuration value |
| wr_ready | output | 1 | Input-ready / not-full, write clock |
| wr_cfg | input | 1 | Marks the write-port transfer as an offset load |
| wr_data | input | 16 | Write data, or offsets when `wr_cfg`=1 |
| almost_full_n | output | 1 | LOW when the memory count is at or above D-Y, write clock |
| rd_clk | input | 1 | Read-side clock |
| fwft_mode | input | 1 | 1 = read-ahead, 0 = standard; static |
| rd_valid | output | 1 | Output-ready (read-ahead) or not-empty (standard), read clock |
| rd_ready | input | 1 | Read request / consume |
| rd_data | output | 16 | Output register |
| almost_empty_n | output | 1 | HIGH when the memory count exceeds X, read clock |

## Verification
Embedded assertions check the following on every cycle of their clock:
- the write-side count never exceeds D;
- a refused write or a configuration transfer leaves the write pointer unchanged;
- almost-full is LOW whenever input-ready is LOW;
- the read pointer advances by at most one per read edge;
- an empty memory keeps almost-empty LOW;
- `rd_data` holds whenever no transfer is allowed in the current mode.

The write-to-flag latencies of two and three read edges, the D+1 capacity in read-ahead mode, the threshold positions before and after reprogramming, and end-to-end data order can only be shown by the bench's timed scenarios. These scenarios compare against values predicted from the clock phase relation.

// File: rtl/dcf_pkg.sv
package dcf_pkg;
  typedef enum logic {
    RD_STANDARD = 1'b0,
    RD_AHEAD    = 1'b1
  } rd_mode_e;
endpackage

// File: rtl/dcf_sync.sv
// Multi-stage synchronizer for a Gray-coded or quasi-static vector.
module dcf_sync #(
  parameter int W      = 5,
  parameter int STAGES = 2,
  parameter logic [W-1:0] INIT = '0
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] d,
  output logic [W-1:0] q
);
  logic [W-1:0] chain [STAGES];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i < STAGES; i++) chain[i] <= INIT;
    end else begin
      chain[0] <= d;
      for (int i = 1; i < STAGES; i++) chain[i] <= chain[i-1];
    end
  end

  assign q = chain[STAGES-1];
endmodule

// File: rtl/dcf_mem.sv
// Inferred dual-port array: synchronous write, asynchronous read.
module dcf_mem #(
  parameter int DW = 16,
  parameter int AW = 4
) (
  input  logic          wclk,
  input  logic          we,
  input  logic [AW-1:0] waddr,
  input  logic [DW-1:0] wdata,
  input  logic [AW-1:0] raddr,
  output logic [DW-1:0] rdata
);
  localparam int DEPTH = 2 ** AW;
  logic [DW-1:0] cells [DEPTH];

  always_ff @(posedge wclk) begin
    if (we) cells[waddr] <= wdata;
  end

  assign rdata = cells[raddr];
endmodule

// File: rtl/dcf_wr.sv
// Write-domain control: pointer, occupancy, input-ready, almost-full, offsets.
module dcf_wr #(
  parameter int AW    = 4,
  parameter int DW    = 16,
  parameter int DEF_X = 2,
  parameter int DEF_Y = 2
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          wr_valid,
  input  logic          wr_cfg,
  input  logic [DW-1:0] wr_data,
  input  logic [AW:0]   rgray_s,
  output logic          wr_ready,
  output logic          af_n,
  output logic          we,
  output logic [AW-1:0] waddr,
  output logic [AW:0]   wgray,
  output logic [AW-1:0] x_cfg
);
  localparam int PW = AW + 1;
  localparam logic [PW-1:0] DEPTH_P = PW'(2 ** AW);

  logic [PW-1:0] wbin, rbin_s, wcount, af_level;
  logic [AW-1:0] y_cfg;
  logic          cfg_take;

  for (genvar i = 0; i < PW; i++) begin : g_rg2b
    assign rbin_s[i] = ^rgray_s[PW-1:i];
  end

  assign wcount   = wbin - rbin_s;
  assign wr_ready = (wcount != DEPTH_P);
  assign af_level = DEPTH_P - {1'b0, y_cfg};
  assign af_n     = (wcount < af_level);
  assign we       = wr_valid && !wr_cfg && wr_ready;
  assign waddr    = wbin[AW-1:0];
  assign cfg_take = wr_valid && wr_cfg;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wbin  <= '0;
      wgray <= '0;
      x_cfg <= AW'(DEF_X);
      y_cfg <= AW'(DEF_Y);
    end else begin
      if (we) begin
        wbin  <= wbin + 1'b1;
        wgray <= (wbin + 1'b1) ^ ((wbin + 1'b1) >> 1);
      end
      if (cfg_take) begin
        x_cfg <= wr_data[AW-1:0];
        y_cfg <= wr_data[2*AW-1:AW];
      end
    end
  end

  AST_NO_OVERFLOW: assert property (@(posedge clk) disable iff (!rst_n)
    wcount <= DEPTH_P); // R2
  AST_REFUSED_WRITE_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_valid && !wr_ready) |=> $stable(wbin)); // R2
  AST_CFG_STORES_NOTHING: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_valid && wr_cfg) |=> $stable(wbin)); // R9
  AST_FULL_IMPLIES_AF: assert property (@(posedge clk) disable iff (!rst_n)
    !wr_ready |-> !af_n); // R8
endmodule

// File: rtl/dcf_rd.sv
// Read-domain control: output register, mode-dependent transfer, flags.
module dcf_rd
  import dcf_pkg::*;
#(
  parameter int AW = 4,
  parameter int DW = 16
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          fwft,
  input  logic          rd_ready,
  input  logic [AW:0]   wgray_s,
  input  logic [AW-1:0] x_s,
  input  logic [DW-1:0] mem_rdata,
  output logic [AW-1:0] raddr,
  output logic [AW:0]   rgray,
  output logic          rd_valid,
  output logic [DW-1:0] rd_data,
  output logic          ae_n
);
  localparam int PW = AW + 1;

  rd_mode_e      mode;
  logic [PW-1:0] rbin, wbin_s, rcount;
  logic          has_word, out_valid, load;

  assign mode = rd_mode_e'(fwft);

  for (genvar i = 0; i < PW; i++) begin : g_wg2b
    assign wbin_s[i] = ^wgray_s[PW-1:i];
  end

  assign rcount   = wbin_s - rbin;
  assign has_word = (rcount != '0);
  assign raddr    = rbin[AW-1:0];
  assign ae_n     = (rcount > {1'b0, x_s});

  always_comb begin
    if (mode == RD_AHEAD) load = has_word && (!out_valid || rd_ready);
    else                  load = has_word && rd_ready;
  end

  assign rd_valid = (mode == RD_AHEAD) ? out_valid : has_word;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rbin      <= '0;
      rgray     <= '0;
      rd_data   <= '0;
      out_valid <= 1'b0;
    end else begin
      if (load) begin
        rd_data <= mem_rdata;
        rbin    <= rbin + 1'b1;
        rgray   <= (rbin + 1'b1) ^ ((rbin + 1'b1) >> 1);
      end
      if (mode == RD_AHEAD) begin
        if (load)          out_valid <= 1'b1;
        else if (rd_ready) out_valid <= 1'b0;
      end else begin
        out_valid <= 1'b0;
      end
    end
  end

  AST_RPTR_STEP: assert property (@(posedge clk) disable iff (!rst_n)
    (rbin == $past(rbin)) || (rbin == $past(rbin) + 1'b1)); // R3
  AST_STD_IGNORED_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
    (!fwft && !rd_valid) |=> $stable(rd_data)); // R3
  AST_AHEAD_STALL_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
    (fwft && rd_valid && !rd_ready) |=> (rd_valid && $stable(rd_data))); // R5
  AST_EMPTY_NOT_AE: assert property (@(posedge clk) disable iff (!rst_n)
    (rcount == '0) |-> !ae_n); // R7
  AST_MODE_STATIC: assert property (@(posedge clk) disable iff (!rst_n)
    $stable(fwft)); // R4
endmodule

// File: rtl/dual_clock_fifo.sv
module dual_clock_fifo #(
  parameter int DATA_W      = 16,
  parameter int ADDR_W      = 4,
  parameter int AE_DEFAULT  = 2,
  parameter int AF_DEFAULT  = 2,
  parameter int SYNC_STAGES = 2
) (
  input  logic              wr_clk,
  input  logic              rst_n,
  input  logic              wr_valid,
  output logic              wr_ready,
  input  logic              wr_cfg,
  input  logic [DATA_W-1:0] wr_data,
  output logic              almost_full_n,
  input  logic              rd_clk,
  input  logic              fwft_mode,
  output logic              rd_valid,
  input  logic              rd_ready,
  output logic [DATA_W-1:0] rd_data,
  output logic              almost_empty_n
);
  localparam int PW = ADDR_W + 1;

  logic [PW-1:0]     wgray, wgray_s, rgray, rgray_s;
  logic [ADDR_W-1:0] waddr, raddr, x_cfg, x_s;
  logic [DATA_W-1:0] mem_rdata;
  logic              we;

  dcf_wr #(.AW(ADDR_W), .DW(DATA_W), .DEF_X(AE_DEFAULT), .DEF_Y(AF_DEFAULT)) u_wr (
    .clk(wr_clk), .rst_n(rst_n), .wr_valid(wr_valid), .wr_cfg(wr_cfg),
    .wr_data(wr_data), .rgray_s(rgray_s), .wr_ready(wr_ready),
    .af_n(almost_full_n), .we(we), .waddr(waddr), .wgray(wgray), .x_cfg(x_cfg)
  );

  dcf_mem #(.DW(DATA_W), .AW(ADDR_W)) u_mem (
    .wclk(wr_clk), .we(we), .waddr(waddr), .wdata(wr_data),
    .raddr(raddr), .rdata(mem_rdata)
  );

  dcf_sync #(.W(PW), .STAGES(SYNC_STAGES)) u_w2r (
    .clk(rd_clk), .rst_n(rst_n), .d(wgray), .q(wgray_s)
  );

  dcf_sync #(.W(PW), .STAGES(SYNC_STAGES)) u_r2w (
    .clk(wr_clk), .rst_n(rst_n), .d(rgray), .q(rgray_s)
  );

  dcf_sync #(.W(ADDR_W), .STAGES(SYNC_STAGES), .INIT(ADDR_W'(AE_DEFAULT))) u_xsync (
    .clk(rd_clk), .rst_n(rst_n), .d(x_cfg), .q(x_s)
  );

  dcf_rd #(.AW(ADDR_W), .DW(DATA_W)) u_rd (
    .clk(rd_clk), .rst_n(rst_n), .fwft(fwft_mode), .rd_ready(rd_ready),
    .wgray_s(wgray_s), .x_s(x_s), .mem_rdata(mem_rdata), .raddr(raddr),
    .rgray(rgray), .rd_valid(rd_valid), .rd_data(rd_data), .ae_n(almost_empty_n)
  );
endmodule

// File: tb/dual_clock_fifo_test.sv
module dual_clock_fifo_test;
  localparam int D = 16;

  logic        wr_clk, rd_clk, rst_n;
  logic        wr_valid, wr_cfg, rd_ready, fwft_mode;
  logic [15:0] wr_data;
  logic        wr_ready, almost_full_n, rd_valid, almost_empty_n;
  logic [15:0] rd_data;

  int checks = 0;
  int fails  = 0;

  dual_clock_fifo uut (
    .wr_clk(wr_clk), .rst_n(rst_n), .wr_valid(wr_valid), .wr_ready(wr_ready),
    .wr_cfg(wr_cfg), .wr_data(wr_data), .almost_full_n(almost_full_n),
    .rd_clk(rd_clk), .fwft_mode(fwft_mode), .rd_valid(rd_valid),
    .rd_ready(rd_ready), .rd_data(rd_data), .almost_empty_n(almost_empty_n)
  );

  initial begin wr_clk = 0; forever #10 wr_clk = ~wr_clk; end
  initial begin rd_clk = 0; #5; forever #10 rd_clk = ~rd_clk; end

  initial begin
    #2ms;
    fails++;
    $display("FAIL watchdog: run did not complete (actual hung, expected done)");
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  task automatic chk(input string req, input string what, input int act, input int exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
    end
  endtask

  task automatic do_reset(input logic mode);
    rst_n = 0; wr_valid = 0; wr_cfg = 0; wr_data = '0; rd_ready = 0;
    fwft_mode = mode;
    repeat (4) @(negedge wr_clk);
    #2 rst_n = 1;
    @(negedge wr_clk);
  endtask

  task automatic push(input logic [15:0] d);
    @(negedge wr_clk);
    wr_valid = 1; wr_data = d;
    while (!wr_ready) @(negedge wr_clk);
    @(negedge wr_clk);
    wr_valid = 0;
  endtask

  task automatic pop(output logic [15:0] d);
    @(negedge rd_clk);
    while (!rd_valid) @(negedge rd_clk);
    if (fwft_mode) begin
      d = rd_data;
      rd_ready = 1;
      @(negedge rd_clk);
      rd_ready = 0;
    end else begin
      rd_ready = 1;
      @(negedge rd_clk);
      rd_ready = 0;
      d = rd_data;
    end
  endtask

  task automatic t_reset();
    do_reset(1'b0);
    chk("R1", "rd_valid", rd_valid, 0);
    chk("R1", "almost_empty_n", almost_empty_n, 0);
    chk("R1", "wr_ready", wr_ready, 1);
    chk("R1", "almost_full_n", almost_full_n, 1);
  endtask

  task automatic t_std_latency();
    logic [15:0] d;
    do_reset(1'b0);
    push(16'h00A1);
    @(negedge rd_clk);
    chk("R3", "rd_valid after 1 read edge", rd_valid, 0);
    rd_ready = 1;
    @(negedge rd_clk);
    chk("R3", "rd_valid after 2 read edges", rd_valid, 1);
    chk("R3", "rd_data held on ignored request", rd_data, 0);
    rd_ready = 0;
    pop(d);
    chk("R3", "loaded word", d, 16'h00A1);
    @(negedge rd_clk);
    chk("R3", "empty after read", rd_valid, 0);
  endtask

  task automatic t_ahead_latency();
    logic [15:0] d;
    do_reset(1'b1);
    push(16'h00B1);
    @(negedge rd_clk);
    chk("R4", "rd_valid after 1 read edge", rd_valid, 0);
    @(negedge rd_clk);
    chk("R4", "rd_valid after 2 read edges", rd_valid, 0);
    @(negedge rd_clk);
    chk("R4", "rd_valid after 3 read edges", rd_valid, 1);
    chk("R4", "presented word", rd_data, 16'h00B1);
    pop(d);
    @(negedge rd_clk);
    chk("R5", "rd_valid falls after consume", rd_valid, 0);
    rd_ready = 1;
    repeat (3) @(negedge rd_clk);
    rd_ready = 0;
    push(16'h00C1); push(16'h00C2); push(16'h00C3);
    repeat (6) @(negedge rd_clk);
    chk("R5", "ignored request lost nothing", rd_data, 16'h00C1);
    rd_ready = 1;
    @(negedge rd_clk);
    chk("R5", "back-to-back second word", rd_data, 16'h00C2);
    @(negedge rd_clk);
    chk("R5", "back-to-back third word", rd_data, 16'h00C3);
    chk("R5", "still valid", rd_valid, 1);
    @(negedge rd_clk);
    chk("R5", "valid falls when drained", rd_valid, 0);
    rd_ready = 0;
  endtask

  task automatic t_fill_std();
    logic [15:0] d;
    do_reset(1'b0);
    for (int n = 1; n <= D; n++) begin
      push(16'(n * 3 + 1));
      repeat (3) @(negedge wr_clk);
      chk("R7", "almost_empty_n vs count", almost_empty_n, int'(n > 2));
      chk("R8", "almost_full_n vs count", almost_full_n, int'(n < D - 2));
      chk("R2", "wr_ready vs count", wr_ready, int'(n < D));
    end
    @(negedge wr_clk);
    wr_valid = 1; wr_data = 16'hDEAD;
    repeat (4) @(negedge wr_clk);
    wr_valid = 0;
    chk("R2", "wr_ready stays low when full", wr_ready, 0);
    for (int n = 1; n <= D; n++) begin
      pop(d);
      chk("R10", "drain order", d, n * 3 + 1);
    end
    repeat (3) @(negedge rd_clk);
    chk("R2", "refused write not stored", rd_valid, 0);
    chk("R7", "almost_empty_n low when empty", almost_empty_n, 0);
  endtask

  task automatic t_ahead_capacity();
    logic [15:0] d;
    do_reset(1'b1);
    push(16'd100);
    repeat (5) @(negedge rd_clk);
    for (int i = 1; i <= D; i++) push(16'(100 + i));
    repeat (4) @(negedge wr_clk);
    chk("R6", "full after D+1 words", wr_ready, 0);
    chk("R8", "almost_full_n low when full", almost_full_n, 0);
    chk("R6", "output word presented", rd_valid, 1);
    for (int i = 0; i <= D; i++) begin
      pop(d);
      chk("R10", "read-ahead order", d, 100 + i);
    end
  endtask

  task automatic t_program();
    logic [15:0] d;
    do_reset(1'b0);
    @(negedge wr_clk);
    wr_valid = 1; wr_cfg = 1; wr_data = 16'h0054;
    @(negedge wr_clk);
    wr_valid = 0; wr_cfg = 0;
    repeat (4) @(negedge wr_clk);
    chk("R9", "config stores no word", rd_valid, 0);
    chk("R9", "wr_ready after config", wr_ready, 1);
    for (int n = 1; n <= 12; n++) begin
      push(16'(n + 500));
      repeat (3) @(negedge wr_clk);
      chk("R9", "programmed almost-empty", almost_empty_n, int'(n > 4));
      chk("R9", "programmed almost-full", almost_full_n, int'(n < D - 5));
    end
    for (int n = 1; n <= 12; n++) begin
      pop(d);
      chk("R10", "order after config", d, n + 500);
    end
  endtask

  task automatic t_stream(input logic mode);
    do_reset(mode);
    fork
      begin
        for (int i = 0; i < 40; i++) begin
          push(16'(1000 + i * 7));
          if (i % 5 == 0) repeat (3) @(negedge wr_clk);
        end
      end
      begin
        logic [15:0] d;
        for (int i = 0; i < 40; i++) begin
          pop(d);
          chk("R10", "stream order", d, 1000 + i * 7);
          if (i % 7 == 0) repeat (4) @(negedge rd_clk);
        end
      end
    join
  endtask

  initial begin
    t_reset();
    t_std_latency();
    t_ahead_latency();
    t_fill_std();
    t_ahead_capacity();
    t_program();
    t_stream(1'b0);
    t_stream(1'b1);
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule